// File: doc/BRIEF.md
# Low-Power Interrupt Capture Controller

This block watches a bank of external interrupt lines while the main interrupt controller is switched off. Each line has its own mask, sensitivity (edge or level) and polarity. When the block is enabled, every qualifying event on an unmasked line is latched as a pending bit. One wake-up output is raised while any bit is pending. After power returns, software reads the pending words, replays the events to the main controller, then masks and acknowledges all lines.

Software reaches the block through a plain 32-bit register port: a word address, a write strobe, write data and combinational read data. Lines are packed 32 to a word. Bits [7:4] of the word address select the bank, and bits [3:0] select the word within it, so line n is bit n%32 of word n/32. The configuration banks have separate write-one-to-set and write-one-to-clear addresses, plus a read address. A global edge-only mode treats every line as edge-sensitive, whatever its own setting.

Top module: `irq_capture`

## Requirements
- R1: After reset, all pending bits are 0, all mask bits are 1 (masked), all sensitivity bits are 0 (edge), all polarity bits are 1 (positive), the control word is 0 and the wake output is 0.
- R2: The mask is read at bank 3. Writing bank 4 sets each mask bit written as 1, and writing bank 5 clears each mask bit written as 1. Bits written as 0 keep their value. A mask bit of 1 means masked.
- R3: Sensitivity is read at bank 6, set at bank 7 and cleared at bank 8, with the same write-one rules. A value of 1 means level-sensitive and 0 means edge-sensitive.
- R4: Polarity is read at bank 9, set at bank 10 and cleared at bank 11, with the same write-one rules. A value of 1 means rising edge or active-high, and 0 means falling edge or active-low.
- R5: Take an enabled block, an unmasked edge-sensitive line, and an input change in the direction its polarity selects. The pending bit of that line, read at bank 1, is 0 two clock edges after the input change and 1 after the third edge. Only one event is latched for each transition.
- R6: A level-sensitive line that stays at its active level sets its pending bit. The bit stays 1 until it is acknowledged after the line has left the active level.
- R7: While edge-only mode (control bit 1) is 1, a level-sensitive line latches only its active edge. An acknowledge given while the line is still active clears the bit.
- R8: No pending bit is set while enable (control bit 0) is 0, or on a line whose mask bit is 1.
- R9: Writing bank 2 clears each pending bit written as 1. If a new event hits a bit in the same cycle as its acknowledge, the bit stays 1.
- R10: The control word lives at address 0x00. Bit 0 is enable and bit 1 is edge-only. Clearing enable leaves edge-only unchanged.
- R11: Writing 1 to control bit 2 starts a software reset. The bit reads back 0 after one cycle. The reset clears all pending bits, sets all mask bits and leaves sensitivity and polarity unchanged.
- R12: The wake output is 1 exactly when at least one pending bit is 1.
- R13: Reads return zero from unused banks, from word indices at or beyond the number of words, and from bank 0 words other than 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_i | input | N_LINES | Raw external interrupt lines |
| bus_addr | input | 4+IDX_W | Word address: bank in the upper 4 bits, word index below |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr |
| wake_o | output | 1 | High while any line is pending |

## Verification
The bench counts the edges between an input change and the pending bit. A design with a missing or extra synchronizer stage shows the wrong latency. It holds a level line active across an acknowledge: a design that lets the acknowledge beat the event would drop an event that is still live. The same case is repeated under edge-only mode, where the acknowledge must win. Random set and clear writes target one word at a time, so a decoder that picks the wrong word or touches bits written as 0 breaks the readback. A soft reset issued with live configuration must leave sensitivity and polarity unchanged while it clears pending bits and sets all mask bits.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
    localparam logic [3:0] BANK_CTRL = 4'd0;
    localparam logic [3:0] BANK_PEND = 4'd1;
    localparam logic [3:0] BANK_ACK  = 4'd2;
    localparam logic [3:0] BANK_MASK = 4'd3;
    localparam logic [3:0] BANK_MSET = 4'd4;
    localparam logic [3:0] BANK_MCLR = 4'd5;
    localparam logic [3:0] BANK_SENS = 4'd6;
    localparam logic [3:0] BANK_SSET = 4'd7;
    localparam logic [3:0] BANK_SCLR = 4'd8;
    localparam logic [3:0] BANK_POL  = 4'd9;
    localparam logic [3:0] BANK_PSET = 4'd10;
    localparam logic [3:0] BANK_PCLR = 4'd11;

    typedef struct packed {
        logic srst;
        logic edge_only;
        logic en;
    } ctrl_t;
endpackage

// File: rtl/irqc_sync.sv
module irqc_sync #(
    parameter int N_LINES = 64
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [N_LINES-1:0] raw_i,
    output logic [N_LINES-1:0] cur_o,
    output logic [N_LINES-1:0] prv_o
);
    typedef struct packed {
        logic [N_LINES-1:0] s1;
        logic [N_LINES-1:0] s2;
        logic [N_LINES-1:0] prv;
    } sync_t;

    sync_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        st_d.s1  = raw_i;
        st_d.s2  = st_q.s1;
        st_d.prv = st_q.s2;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cur_o = st_q.s2;
    assign prv_o = st_q.prv;
endmodule

// File: rtl/irqc_detect.sv
module irqc_detect #(
    parameter int N_LINES = 64
) (
    input  logic [N_LINES-1:0] cur_i,
    input  logic [N_LINES-1:0] prv_i,
    input  logic [N_LINES-1:0] pol_i,
    input  logic [N_LINES-1:0] sens_i,
    input  logic [N_LINES-1:0] mask_i,
    input  logic               en_i,
    input  logic               edge_only_i,
    output logic [N_LINES-1:0] hit_o
);
    for (genvar i = 0; i < N_LINES; i++) begin : g_line
        logic edge_hit, lvl_hit, use_lvl;
        assign edge_hit = pol_i[i] ? (cur_i[i] & ~prv_i[i]) : (~cur_i[i] & prv_i[i]);
        assign lvl_hit  = pol_i[i] ? cur_i[i] : ~cur_i[i];
        assign use_lvl  = sens_i[i] & ~edge_only_i;
        assign hit_o[i] = en_i & ~mask_i[i] & (use_lvl ? lvl_hit : edge_hit);
    end
endmodule

// File: rtl/irqc_regs.sv
module irqc_regs
    import irqc_pkg::*;
#(
    parameter int N_LINES = 64,
    parameter int IDX_W   = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [3+IDX_W:0]   addr_i,
    input  logic               we_i,
    input  logic [31:0]        wdata_i,
    output logic [31:0]        rdata_o,
    input  logic [N_LINES-1:0] hit_i,
    output logic [N_LINES-1:0] pend_o,
    output logic [N_LINES-1:0] mask_o,
    output logic [N_LINES-1:0] sens_o,
    output logic [N_LINES-1:0] pol_o,
    output logic               en_o,
    output logic               edge_only_o
);
    localparam int WORDS = N_LINES / 32;

    typedef struct packed {
        logic [N_LINES-1:0] pend;
        logic [N_LINES-1:0] mask;
        logic [N_LINES-1:0] sens;
        logic [N_LINES-1:0] pol;
        ctrl_t              ctrl;
    } regs_t;

    regs_t st_d, st_q;
    logic [3:0]         bank;
    logic [IDX_W-1:0]   idx;
    logic [N_LINES-1:0] wfull;
    logic               w_ack, w_mset, w_mclr, w_sset, w_sclr, w_pset, w_pclr;

    assign bank = addr_i[3+IDX_W:IDX_W];
    assign idx  = addr_i[IDX_W-1:0];

    always_comb begin
        for (int w = 0; w < WORDS; w++)
            wfull[w*32 +: 32] = (we_i && idx == IDX_W'(w)) ? wdata_i : 32'd0;
    end

    assign w_ack  = we_i && bank == BANK_ACK;
    assign w_mset = we_i && bank == BANK_MSET;
    assign w_mclr = we_i && bank == BANK_MCLR;
    assign w_sset = we_i && bank == BANK_SSET;
    assign w_sclr = we_i && bank == BANK_SCLR;
    assign w_pset = we_i && bank == BANK_PSET;
    assign w_pclr = we_i && bank == BANK_PCLR;

    always_comb begin
        st_d      = st_q;
        st_d.pend = (st_q.pend & ~(w_ack ? wfull : '0)) | hit_i;
        st_d.mask = (st_q.mask | (w_mset ? wfull : '0)) & ~(w_mclr ? wfull : '0);
        st_d.sens = (st_q.sens | (w_sset ? wfull : '0)) & ~(w_sclr ? wfull : '0);
        st_d.pol  = (st_q.pol  | (w_pset ? wfull : '0)) & ~(w_pclr ? wfull : '0);
        if (we_i && bank == BANK_CTRL && idx == '0) begin
            st_d.ctrl.en        = wdata_i[0];
            st_d.ctrl.edge_only = wdata_i[1];
            st_d.ctrl.srst      = wdata_i[2];
        end
        if (st_q.ctrl.srst) begin
            st_d.pend      = '0;
            st_d.mask      = '1;
            st_d.ctrl.srst = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q      <= '0;
            st_q.mask <= '1;
            st_q.pol  <= '1;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        rdata_o = 32'd0;
        if (bank == BANK_CTRL) begin
            if (idx == '0) rdata_o = {29'd0, st_q.ctrl.srst, st_q.ctrl.edge_only, st_q.ctrl.en};
        end else begin
            for (int w = 0; w < WORDS; w++) begin
                if (idx == IDX_W'(w)) begin
                    case (bank)
                        BANK_PEND: rdata_o = st_q.pend[w*32 +: 32];
                        BANK_MASK: rdata_o = st_q.mask[w*32 +: 32];
                        BANK_SENS: rdata_o = st_q.sens[w*32 +: 32];
                        BANK_POL:  rdata_o = st_q.pol[w*32 +: 32];
                        default:   rdata_o = 32'd0;
                    endcase
                end
            end
        end
    end

    assign pend_o      = st_q.pend;
    assign mask_o      = st_q.mask;
    assign sens_o      = st_q.sens;
    assign pol_o       = st_q.pol;
    assign en_o        = st_q.ctrl.en;
    assign edge_only_o = st_q.ctrl.edge_only;

    p_srst_clears_r11: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.ctrl.srst |=> (st_q.pend == '0 && st_q.mask == '1 && !st_q.ctrl.srst));

    p_srst_keeps_cfg_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.ctrl.srst && !(w_sset || w_sclr || w_pset || w_pclr)) |=> ($stable(st_q.sens) && $stable(st_q.pol)));

    p_masked_no_new_r8: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((st_q.pend & ~$past(st_q.pend) & $past(st_q.mask)) == '0));

    p_disabled_no_new_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !st_q.ctrl.en |=> ((st_q.pend & ~$past(st_q.pend)) == '0));

    p_ack_clears_r9: assert property (@(posedge clk) disable iff (!rst_n)
        w_ack |=> ((st_q.pend & $past(wfull) & ~$past(hit_i)) == '0));
endmodule

// File: rtl/irq_capture.sv
module irq_capture #(
    parameter int N_LINES = 64,
    parameter int IDX_W   = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [N_LINES-1:0] irq_i,
    input  logic [3+IDX_W:0]   bus_addr,
    input  logic               bus_we,
    input  logic [31:0]        bus_wdata,
    output logic [31:0]        bus_rdata,
    output logic               wake_o
);
    localparam int WORDS = N_LINES / 32;

    initial begin
        if (N_LINES % 32 != 0 || WORDS > (1 << IDX_W))
            $error("N_LINES must be a multiple of 32 that fits the word index");
    end

    logic [N_LINES-1:0] cur, prv, hit, pend, mask, sens, pol;
    logic               en, edge_only;

    irqc_sync #(.N_LINES(N_LINES)) u_sync (
        .clk(clk), .rst_n(rst_n), .raw_i(irq_i), .cur_o(cur), .prv_o(prv)
    );

    irqc_detect #(.N_LINES(N_LINES)) u_detect (
        .cur_i(cur), .prv_i(prv), .pol_i(pol), .sens_i(sens), .mask_i(mask),
        .en_i(en), .edge_only_i(edge_only), .hit_o(hit)
    );

    irqc_regs #(.N_LINES(N_LINES), .IDX_W(IDX_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .addr_i(bus_addr), .we_i(bus_we),
        .wdata_i(bus_wdata), .rdata_o(bus_rdata), .hit_i(hit),
        .pend_o(pend), .mask_o(mask), .sens_o(sens), .pol_o(pol),
        .en_o(en), .edge_only_o(edge_only)
    );

    assign wake_o = |pend;

    p_edge_needs_change_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ((hit & (~sens | {N_LINES{edge_only}}) & ~(cur ^ prv)) == '0));
endmodule

// File: tb/test_irq_capture.sv
`timescale 1ns/1ps
module test_irq_capture;
    localparam int N = 64;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [N-1:0]  irq = '0;
    logic [7:0]    addr = '0;
    logic          we = 1'b0;
    logic [31:0]   wdata = '0;
    logic [31:0]   rdata;
    logic          wake;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    logic [N-1:0] m_mask, m_sens, m_pol, m_pend;

    always #2 clk = ~clk;

    irq_capture #(.N_LINES(N), .IDX_W(4)) i_irq_capture (
        .clk(clk), .rst_n(rst_n), .irq_i(irq), .bus_addr(addr), .bus_we(we),
        .bus_wdata(wdata), .bus_rdata(rdata), .wake_o(wake)
    );

    function automatic logic [7:0] ad(input int bank, input int idx);
        return {4'(bank), 4'(idx)};
    endfunction

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        addr = a; we = 1'b1; wdata = d;
        @(negedge clk);
        we = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        addr = a;
        #0.5;
        d = rdata;
    endtask

    task automatic rd64(input int bank, output logic [63:0] v);
        logic [31:0] lo, hi;
        rd(ad(bank, 0), lo);
        rd(ad(bank, 1), hi);
        v = {hi, lo};
    endtask

    // configuration write that also updates the bench model
    task automatic cfg(input int bank, input int idx, input logic [31:0] d);
        logic [63:0] f;
        f = '0;
        f[idx*32 +: 32] = d;
        wr(ad(bank, idx), d);
        case (bank)
            4:  m_mask = m_mask | f;
            5:  m_mask = m_mask & ~f;
            7:  m_sens = m_sens | f;
            8:  m_sens = m_sens & ~f;
            10: m_pol  = m_pol | f;
            11: m_pol  = m_pol & ~f;
            default: ;
        endcase
    endtask

    task automatic drive(input logic [N-1:0] v, input int wait_cyc);
        @(negedge clk);
        irq = v;
        repeat (wait_cyc) @(negedge clk);
    endtask

    task automatic ack_all();
        wr(ad(2, 0), 32'hFFFF_FFFF);
        wr(ad(2, 1), 32'hFFFF_FFFF);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [63:0] v;
        logic [31:0] w;
        void'($urandom(32'd20240611));
        m_mask = '1; m_sens = '0; m_pol = '1; m_pend = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        rd64(1, v); chk("R1 pending", v, '0);
        rd64(3, v); chk("R1 mask", v, '1);
        rd64(6, v); chk("R1 sens", v, '0);
        rd64(9, v); chk("R1 pol", v, '1);
        rd(ad(0, 0), w); chk("R1 ctrl", w, 0);
        chk("R1 wake", wake, 0);

        // R13 undefined reads
        rd(ad(0, 1), w);  chk("R13 bank0 word1", w, 0);
        rd(ad(3, 2), w);  chk("R13 index beyond words", w, 0);
        rd(ad(15, 0), w); chk("R13 unused bank", w, 0);
        rd(ad(4, 0), w);  chk("R13 write-only bank", w, 0);

        // R10 control bits
        wr(ad(0, 0), 32'h3); rd(ad(0, 0), w); chk("R10 en+edge", w, 3);
        wr(ad(0, 0), 32'h2); rd(ad(0, 0), w); chk("R10 clear en keeps edge", w, 2);
        wr(ad(0, 0), 32'h0);

        // R2 R3 R4 random set/clear writes
        for (int it = 0; it < 40; it++) begin
            int sel;
            int banks[6];
            banks = '{4, 5, 7, 8, 10, 11};
            sel = $urandom_range(0, 5);
            cfg(banks[sel], $urandom_range(0, 1), $urandom);
            if (it % 8 == 7) begin
                rd64(3, v); chk("R2 mask readback", v, m_mask);
                rd64(6, v); chk("R3 sens readback", v, m_sens);
                rd64(9, v); chk("R4 pol readback", v, m_pol);
            end
        end

        // known configuration for directed capture tests
        cfg(11, 0, 32'hFFFF_FFFF); cfg(11, 1, 32'hFFFF_FFFF);
        cfg(10, 0, 32'hFFFF_FFFF); cfg(10, 1, 32'hFFFF_FFFF);
        cfg(8, 0, 32'hFFFF_FFFF);  cfg(8, 1, 32'hFFFF_FFFF);
        cfg(4, 0, 32'hFFFF_FFFF);  cfg(4, 1, 32'hFFFF_FFFF);
        cfg(5, 0, 32'h0000_0028);  cfg(5, 1, 32'h0000_0001); // lines 3, 5, 32
        rd64(3, v); chk("R2 mask clear selected", v, ~64'h1_0000_0028);
        ack_all();
        wr(ad(0, 0), 32'h1);

        // R5 latency on a rising edge of line 3
        @(negedge clk); irq[3] = 1'b1;
        repeat (2) @(negedge clk);
        rd64(1, v); chk("R5 not yet pending after two edges", v, 0);
        @(negedge clk);
        rd64(1, v); chk("R5 pending after third edge", v, 64'h8);
        chk("R12 wake with pending", wake, 1);
        ack_all();
        rd64(1, v); chk("R5 one event per transition", v, 0);
        chk("R12 wake cleared", wake, 0);

        // R5 falling edge on line 32 with negative polarity
        cfg(11, 1, 32'h1);
        drive(irq | 64'h1_0000_0000, 5);
        rd64(1, v); chk("R5 rising ignored on falling line", v, 0);
        drive(irq & ~64'h1_0000_0000, 5);
        rd64(1, v); chk("R5 falling captured", v, 64'h1_0000_0000);
        ack_all();

        // R6 R9 level line 5 active high
        cfg(7, 0, 32'h20);
        drive(irq | 64'h20, 5);
        rd64(1, v); chk("R6 level pending", v, 64'h20);
        wr(ad(2, 0), 32'h20);
        rd64(1, v); chk("R9 event beats ack", v, 64'h20);
        drive(irq & ~64'h20, 5);
        rd64(1, v); chk("R6 held after line inactive", v, 64'h20);
        wr(ad(2, 0), 32'h20);
        rd64(1, v); chk("R9 ack clears", v, 0);

        // R7 edge-only overrides level line 5
        wr(ad(0, 0), 32'h3);
        drive(irq | 64'h20, 5);
        rd64(1, v); chk("R7 edge captured", v, 64'h20);
        wr(ad(2, 0), 32'h20);
        repeat (3) @(negedge clk);
        rd64(1, v); chk("R7 ack wins while active", v, 0);
        drive(irq & ~64'h20, 5);
        wr(ad(0, 0), 32'h1);

        // R8 disabled and masked
        wr(ad(0, 0), 32'h0);
        drive(irq | 64'h8, 5);
        rd64(1, v); chk("R8 disabled no capture", v, 0);
        drive(irq & ~64'h8, 5);
        wr(ad(0, 0), 32'h1);
        cfg(4, 0, 32'h8);
        drive(irq | 64'h8, 5);
        rd64(1, v); chk("R8 masked no capture", v, 0);
        chk("R12 wake idle", wake, 0);
        drive(irq & ~64'h8, 5);

        // R5 random edge capture across all lines
        cfg(8, 0, 32'hFFFF_FFFF); cfg(8, 1, 32'hFFFF_FFFF);
        begin
            logic [63:0] r;
            r = {$urandom, $urandom};
            cfg(10, 0, r[31:0]);  cfg(11, 0, ~r[31:0]);
            cfg(10, 1, r[63:32]); cfg(11, 1, ~r[63:32]);
            r = {$urandom, $urandom};
            cfg(4, 0, r[31:0]);   cfg(5, 0, ~r[31:0]);
            cfg(4, 1, r[63:32]);  cfg(5, 1, ~r[63:32]);
        end
        ack_all();
        m_pend = '0;
        for (int it = 0; it < 30; it++) begin
            logic [N-1:0] nv, rise, fall;
            nv = {$urandom, $urandom};
            rise = nv & ~irq;
            fall = ~nv & irq;
            m_pend = m_pend | (~m_mask & ((m_pol & rise) | (~m_pol & fall)));
            drive(nv, 5);
            rd64(1, v); chk("R5 random capture", v, m_pend);
            chk("R12 wake random", wake, m_pend != 0);
            if (it % 10 == 9) begin
                logic [31:0] a;
                a = $urandom;
                wr(ad(2, 0), a);
                m_pend[31:0] = m_pend[31:0] & ~a;
                rd64(1, v); chk("R9 partial ack", v, m_pend);
            end
        end

        // R11 software reset
        drive(irq | 64'h1, 0);
        cfg(5, 0, 32'h1);
        drive(irq, 5);
        wr(ad(0, 0), 32'h5);
        @(negedge clk);
        rd(ad(0, 0), w); chk("R11 reset bit self-clears", w, 1);
        rd64(1, v); chk("R11 pending cleared", v, 0);
        rd64(3, v); chk("R11 all masked", v, '1);
        rd64(6, v); chk("R11 sens kept", v, m_sens);
        rd64(9, v); chk("R11 pol kept", v, m_pol);
        chk("R11 wake low", wake, 0);

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule